// File: doc/BRIEF.md
# Multi-bank SDRAM command sequencer

This block turns simple read and write requests into the command stream for a four-bank, burst-oriented DRAM. Each request carries a bank, a row, a column, a direction and an optional auto-precharge flag. The sequencer keeps a table of which row is open in each bank. A request that hits the open row goes straight to a column command. A request to a closed bank first gets an activate. A request to a bank that has a different row open gets a precharge, then an activate, then the column command.

One command at most leaves the block per rising clock edge, and the command outputs are registered. A single recovery counter holds off the next command until the activate-to-column, precharge, refresh-cycle or burst time of the last command has passed. A free-running timer raises a refresh demand every `REF_INT` clocks. Open banks are then closed with a precharge-all, and an auto refresh is issued before any further request is served. Read-data-valid pulses CAS latency clocks after each read. The CAS latency is given in half clocks and must be a whole number of clocks; odd values stop elaboration.

Top module: `sdram_cmd_seq`

## Requirements
- R1: `cmd_o` codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4 (one bank), PREA=5 (all banks), REF=6, and no other value appears. During and right after reset, `cmd_o` is NOP and `rd_valid` and `req_ready` are low.
- R2: A request whose bank has the requested row open is accepted (`req_ready` high with `req_valid`) with no ACT or PRE. In the next cycle `cmd_o` is RD (`req_write`=0) or WR (`req_write`=1), `cmd_bank` is the bank, `cmd_addr` holds the column, and `cmd_ap` holds the auto-precharge flag.
- R3: A request to a closed bank produces ACT, with `cmd_addr` equal to the row. The column command follows exactly `T_RCD` cycles after the ACT, and no command follows an ACT sooner than that.
- R4: A request to a bank with a different row open produces PRE to that bank. ACT follows exactly `T_RP` cycles later, then the column command.
- R5: A column command with auto precharge leaves its bank closed, so the next request to that bank gets ACT with no PRE. No command follows sooner than `BURST_CYC + T_RP` cycles.
- R6: A column command without auto precharge is followed by no command for at least `BURST_CYC` cycles.
- R7: `rd_valid` is high for one cycle exactly CAS latency (`CL_X2/2`) cycles after each RD on `cmd_o`, and at no other time.
- R8: A refresh demand arises every `REF_INT` clocks. If any bank is open, PREA is issued and REF follows exactly `T_RP` cycles later. With all banks closed and no requests, consecutive REF commands are exactly `REF_INT` cycles apart.
- R9: No command follows REF for `T_RFC` cycles. No request is accepted while a refresh is pending, so a request held across a refresh completes no sooner than `T_RP + T_RFC + T_RCD` cycles after the PREA.
- R10: Banks are independent. Opening or changing a row in one bank does not change whether another bank's open row hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands issue on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (its column command is decided) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Close the row after this burst |
| cmd_o | output | 3 | Command code (see R1) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row for ACT, column for RD/WR, zero otherwise |
| cmd_ap | output | 1 | Auto precharge with RD/WR |
| rd_valid | output | 1 | Read data expected this cycle |

## Verification
A wrong entry in the open-row table shows within one request: an ACT to a bank that is already open, a missing PRE, or a column command reaching the port with no ACT before it. A recovery counter that reloads wrongly moves the next command on `cmd_o` by one or more clocks, which the spacing between consecutive commands exposes at once. A fault in the refresh timer moves the REF-to-REF spacing of an idle bus away from `REF_INT`. A refresh that fails to block requests lets a column command arrive too soon after the PREA.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_bank_table.sv
`timescale 1ns/1ps
module seq_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_open,
  output logic              lk_hit,
  output logic              any_open,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else if (close_all) begin
        open_q[g] <= 1'b0;
      end else if (upd_bank == BANK_W'(g)) begin
        if (open_en) begin
          open_q[g] <= 1'b1;
          row_q[g]  <= upd_row;
        end else if (close_en) begin
          open_q[g] <= 1'b0;
        end
      end
    end
  end

  assign lk_open  = open_q[lk_bank];
  assign lk_hit   = lk_open && (row_q[lk_bank] == lk_row);
  assign any_open = |open_q;

endmodule

// File: rtl/seq_refresh_timer.sv
`timescale 1ns/1ps
module seq_refresh_timer #(
  parameter int REF_INT = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_pend
);

  localparam int CNT_W = $clog2(REF_INT);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == CNT_W'(REF_INT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ref_pend <= 1'b0;
    end else begin
      cnt_q    <= tick ? '0 : cnt_q + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_done);
    end
  end

endmodule

// File: rtl/seq_rd_pipe.sv
`timescale 1ns/1ps
module seq_rd_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cmd,
  output logic rd_valid
);

  logic [DEPTH-1:0] pipe_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe_q[i] <= 1'b0;
      else if (i == 0) pipe_q[i] <= rd_cmd;
      else             pipe_q[i] <= pipe_q[(i == 0) ? 0 : i - 1];
    end
  end

  assign rd_valid = pipe_q[DEPTH-1];

endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int BURST_CYC = 2,
  parameter int CL_X2     = 4,
  parameter int REF_INT   = 780,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = seq_pkg::max2(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap,
  output logic              rd_valid
);
  import seq_pkg::*;

  localparam int CAS_LAT  = CL_X2 / 2;
  localparam int WAIT_MAX = T_RFC + T_RP + T_RCD + BURST_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  if ((CL_X2 % 2) != 0 || CL_X2 < 2) begin : g_bad_cl
    $error("CAS latency must be a whole number of clocks, at least one");
  end

  // Clocks the sequencer must stay silent after issuing command c.
  function automatic logic [WAIT_W-1:0] recovery(input cmd_e c, input logic ap);
    case (c)
      CMD_ACT:           return WAIT_W'(T_RCD - 1);
      CMD_PRE, CMD_PREA: return WAIT_W'(T_RP - 1);
      CMD_REF:           return WAIT_W'(T_RFC - 1);
      CMD_RD, CMD_WR:    return ap ? WAIT_W'(BURST_CYC + T_RP - 1) : WAIT_W'(BURST_CYC - 1);
      default:           return '0;
    endcase
  endfunction

  // Named internal events, observed by the bound checker.
  logic [WAIT_W-1:0] wait_q;
  logic              ref_pend;
  logic              ref_issue;
  logic              lk_open, lk_hit, any_open;
  logic              open_en, close_en, close_all;

  cmd_e              dec_cmd;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_ap;
  logic [2:0]        cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ap_q;

  seq_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .lk_bank(req_bank), .lk_row(req_row),
    .lk_open(lk_open), .lk_hit(lk_hit), .any_open(any_open),
    .open_en(open_en), .close_en(close_en), .close_all(close_all),
    .upd_bank(req_bank), .upd_row(req_row)
  );

  seq_refresh_timer #(.REF_INT(REF_INT)) u_refresh (
    .clk(clk), .rst_n(rst_n), .ref_done(ref_issue), .ref_pend(ref_pend)
  );

  seq_rd_pipe #(.DEPTH(CAS_LAT)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .rd_cmd(cmd_q == CMD_RD), .rd_valid(rd_valid)
  );

  always_comb begin
    dec_cmd   = CMD_NOP;
    dec_addr  = '0;
    dec_ap    = 1'b0;
    req_ready = 1'b0;
    open_en   = 1'b0;
    close_en  = 1'b0;
    close_all = 1'b0;
    ref_issue = 1'b0;
    if (wait_q == '0) begin
      if (ref_pend) begin
        if (any_open) begin
          dec_cmd   = CMD_PREA;
          close_all = 1'b1;
        end else begin
          dec_cmd   = CMD_REF;
          ref_issue = 1'b1;
        end
      end else if (req_valid) begin
        if (lk_hit) begin
          dec_cmd   = req_write ? CMD_WR : CMD_RD;
          dec_addr  = ADDR_W'(req_col);
          dec_ap    = req_autopre;
          close_en  = req_autopre;
          req_ready = 1'b1;
        end else if (lk_open) begin
          dec_cmd  = CMD_PRE;
          close_en = 1'b1;
        end else begin
          dec_cmd  = CMD_ACT;
          dec_addr = ADDR_W'(req_row);
          open_en  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      wait_q <= '0;
    end else begin
      cmd_q  <= dec_cmd;
      bank_q <= (dec_cmd == CMD_NOP || dec_cmd == CMD_PREA || dec_cmd == CMD_REF) ? '0 : req_bank;
      addr_q <= dec_addr;
      ap_q   <= dec_ap;
      wait_q <= (wait_q != '0) ? wait_q - 1'b1 : recovery(dec_cmd, dec_ap);
    end
  end

  assign cmd_o    = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;
  assign cmd_ap   = ap_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk #(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int BURST_CYC = 2,
  parameter int CAS_LAT   = 2,
  parameter int WAIT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [2:0]        cmd_o,
  input logic              cmd_ap,
  input logic              rd_valid,
  input logic              ref_pend,
  input logic [WAIT_W-1:0] wait_q
);

  logic [15:0] gap_q;
  logic [2:0]  last_q;
  logic        last_ap_q;
  logic        is_col;

  assign is_col = (cmd_o == 3'd2) || (cmd_o == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      last_q    <= 3'd0;
      last_ap_q <= 1'b0;
    end else if (cmd_o != 3'd0) begin
      gap_q     <= 16'd1;
      last_q    <= cmd_o;
      last_ap_q <= cmd_ap && is_col;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 16'd1;
    end
  end

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd6);

  p_busy_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != '0) |=> (cmd_o == 3'd0));

  p_accept_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> ((cmd_o == 3'd2) || (cmd_o == 3'd3)));

  p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && (last_q == 3'd1)) |-> (gap_q >= 16'(T_RCD)));

  p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && (last_q == 3'd4)) |-> (gap_q >= 16'(T_RP)));

  p_ap_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && last_ap_q) |-> (gap_q >= 16'(BURST_CYC + T_RP)));

  p_col_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && ((last_q == 3'd2) || (last_q == 3'd3))) |-> (gap_q >= 16'(BURST_CYC)));

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(cmd_o == 3'd2, CAS_LAT));

  p_prea_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && (last_q == 3'd5)) |-> ((cmd_o == 3'd6) && (gap_q == 16'(T_RP))));

  p_ref_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 3'd0) && (last_q == 3'd6)) |-> (gap_q >= 16'(T_RFC)));

  p_ref_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .BURST_CYC(BURST_CYC),
  .CAS_LAT(CAS_LAT), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_o(cmd_o),
  .cmd_ap(cmd_ap), .rd_valid(rd_valid), .ref_pend(ref_pend), .wait_q(wait_q)
);

// File: tb/sdram_cmd_seq_bench.sv
`timescale 1ns/1ps
module sdram_cmd_seq_bench;

  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_RFC = 10;
  localparam int BURST = 2;
  localparam int CL_X2 = 4;
  localparam int CAS   = CL_X2 / 2;
  localparam int REFI  = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_autopre = 1'b0;
  logic [2:0]  cmd_o;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_ap;
  logic        rd_valid;

  always #10 clk = ~clk;

  sdram_cmd_seq #(
    .NUM_BANKS(4), .ROW_W(13), .COL_W(10), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .BURST_CYC(BURST), .CL_X2(CL_X2), .REF_INT(REFI)
  ) u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_autopre(req_autopre), .cmd_o(cmd_o),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .rd_valid(rd_valid)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, actual, expected);
    end
  endtask

  // Monitor: command spacing, read-valid timing, event times.
  int cyc = 0;
  int t_last = -1;
  int last_cmd = 0;
  bit last_ap = 0;
  int n_act = 0, n_pre = 0, n_prea = 0, n_ref = 0;
  int t_act = 0, t_pre = 0, t_prea = 0, t_ref = 0, t_ref_prev = 0;
  int act_bank = 0, act_row = 0;
  bit [7:0] hist = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit exp_rd;
      exp_rd = hist[CAS-1];
      if (exp_rd || rd_valid) chk(rd_valid == exp_rd, "R7 rd_valid timing", int'(rd_valid), int'(exp_rd));
      hist = {hist[6:0], (cmd_o == 3'd2)};
      if (cmd_o != 3'd0) begin
        chk(cmd_o <= 3'd6, "R1 legal code", int'(cmd_o), 6);
        if (t_last >= 0) begin
          int need;
          string tag;
          case (last_cmd)
            1: begin need = T_RCD; tag = "R3 gap after ACT"; end
            4: begin need = T_RP;  tag = "R4 gap after PRE"; end
            5: begin need = T_RP;  tag = "R8 gap after PREA"; end
            6: begin need = T_RFC; tag = "R9 gap after REF"; end
            default: begin
              need = last_ap ? BURST + T_RP : BURST;
              tag  = last_ap ? "R5 gap after auto-precharge" : "R6 gap after column";
            end
          endcase
          chk(cyc - t_last >= need, tag, cyc - t_last, need);
          if (cmd_o == 3'd6 && last_cmd == 5)
            chk(cyc - t_last == T_RP, "R8 PREA to REF", cyc - t_last, T_RP);
        end
        case (cmd_o)
          3'd1: begin n_act++; t_act = cyc; act_bank = int'(cmd_bank); act_row = int'(cmd_addr); end
          3'd4: begin n_pre++; t_pre = cyc; end
          3'd5: begin n_prea++; t_prea = cyc; end
          3'd6: begin n_ref++; t_ref_prev = t_ref; t_ref = cyc; end
          default: ;
        endcase
        t_last   = cyc;
        last_cmd = int'(cmd_o);
        last_ap  = cmd_ap && (cmd_o == 3'd2 || cmd_o == 3'd3);
      end
    end
  end

  // Bench model of the open rows.
  bit m_open [4];
  int m_row  [4];

  task automatic clear_model();
    for (int i = 0; i < 4; i++) m_open[i] = 0;
  endtask

  task automatic do_req(input bit w, input int b, input int r, input int c, input bit ap);
    int pre0, act0, exp_pre, exp_act, k;
    @(negedge clk); #1;
    pre0 = n_pre;
    act0 = n_act;
    if (m_open[b] && m_row[b] == r) begin exp_pre = 0; exp_act = 0; end
    else if (m_open[b])             begin exp_pre = 1; exp_act = 1; end
    else                            begin exp_pre = 0; exp_act = 1; end
    req_write = w; req_bank = 2'(b); req_row = 13'(r); req_col = 10'(c);
    req_autopre = ap; req_valid = 1'b1;
    #1;
    k = 0;
    while (!req_ready && k < 400) begin @(negedge clk); #1; k++; end
    chk(req_ready, "R2 request accepted", int'(req_ready), 1);
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk(cmd_o == (w ? 3'd3 : 3'd2), "R2 column command kind", int'(cmd_o), w ? 3 : 2);
    chk(cmd_bank == 2'(b), "R2 column bank", int'(cmd_bank), b);
    chk(cmd_addr == 13'(c), "R2 column address", int'(cmd_addr), c);
    chk(cmd_ap == ap, "R2 auto-precharge flag", int'(cmd_ap), int'(ap));
    chk(n_pre - pre0 == exp_pre, (exp_act == 0) ? "R10 hit needs no PRE" : "R4 PRE count (R5 after auto-precharge)",
        n_pre - pre0, exp_pre);
    chk(n_act - act0 == exp_act, (exp_act == 0) ? "R2 hit needs no ACT" : "R3 ACT count",
        n_act - act0, exp_act);
    if (exp_act == 1) begin
      chk(act_bank == b && act_row == r, "R3 ACT bank and row", act_row, r);
      chk(t_last - t_act == T_RCD, "R3 ACT to column", t_last - t_act, T_RCD);
    end
    if (exp_pre == 1)
      chk(t_act - t_pre == T_RP, "R4 PRE to ACT", t_act - t_pre, T_RP);
    m_open[b] = !ap;
    m_row[b]  = r;
  endtask

  initial begin
    clear_model();
    repeat (5) @(negedge clk);
    chk(cmd_o == 3'd0, "R1 reset command", int'(cmd_o), 0);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
    chk(req_ready == 1'b0, "R1 reset ready", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_o == 3'd0, "R1 idle after reset", int'(cmd_o), 0);

    // Directed: closed, hit, other bank, hit again, miss, auto precharge, reopen.
    do_req(0, 0, 5, 3, 0);
    do_req(1, 0, 5, 4, 0);
    do_req(0, 1, 7, 8, 0);
    do_req(0, 0, 5, 9, 0);   // R10: bank 1 activity leaves bank 0 hit
    do_req(1, 0, 6, 2, 0);
    do_req(0, 0, 6, 1, 1);
    do_req(0, 0, 6, 5, 0);   // R5: closed by auto precharge
    do_req(1, 1, 7, 6, 1);
    do_req(1, 1, 7, 7, 0);

    // Sweep over banks, rows, directions and auto precharge.
    for (int i = 0; i < 48; i++)
      do_req(bit'(i % 2) ^ bit'((i / 8) % 2), i % 4, (i / 4) % 3, i % 16, (i % 5) == 0);

    // Refresh cadence on an idle bus.
    begin
      int r0, k;
      r0 = n_ref;
      k = 0;
      while (n_ref < r0 + 3 && k < 8000) begin @(negedge clk); #1; k++; end
      chk(n_ref >= r0 + 3, "R8 refreshes issued", n_ref - r0, 3);
      chk(t_ref - t_ref_prev == REFI, "R8 refresh interval", t_ref - t_ref_prev, REFI);
      clear_model();
    end

    // Refresh takes priority over a held request.
    begin
      int p0, k;
      do_req(0, 2, 3, 1, 0);
      p0 = n_prea;
      k = 0;
      while (n_prea == p0 && k < 3000) begin @(negedge clk); #1; k++; end
      chk(n_prea > p0, "R8 precharge-all before refresh", n_prea - p0, 1);
      clear_model();
      do_req(1, 2, 3, 9, 0);
      chk(t_last - t_prea >= T_RP + T_RFC + T_RCD, "R9 request held across refresh",
          t_last - t_prea, T_RP + T_RFC + T_RCD);
    end

    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule